// File: doc/BRIEF.md
# Compare-Match Event Timer

This block is an up-counting timer that sits on a plain register bus. The bus has an address, a write strobe, write data and combinational read data. Software loads a compare value, picks a count rate and starts the counter. The block sends a one-cycle pulse on its event output each time the count steps away from the compare value. A mode bit returns the count to zero at that step, which turns the one-shot compare into a periodic tick. A separate write-only strobe location clears the count at any time.

A small rate divider makes a count-enable strobe every 1, 2, 3 or 4 input clocks. The count therefore advances more slowly than the bus clock without a second clock domain. The count register can be read but not written. The clear location is the only way to move the count other than counting.

Byte offsets on the bus: compare value at 0x00, count at 0x04, control at 0x08, clear strobe at 0x0C, rate divider at 0x10. Any other address, including one that is not a multiple of four, reads zero and ignores writes.

Top module: `evt_timer`

## Requirements
- R1: After synchronous reset the control field reads 0, the count reads 0, the compare value reads all ones, the divider reads 0 and the event output is low.
- R2: The compare value reads back exactly as written. The control location reads back only its two low bits. The divider location reads back only its two low bits. The clear location and any unmapped or unaligned address read zero.
- R3: While control bit 0 (run) is 1, the count rises by one on every count-enable strobe. A write to the count location has no effect on the count.
- R4: A write that sets the run bit to 0 lets the count take the step due at that write's clock edge. From the next edge on, the count holds its value.
- R5: Any write to the clear location sets the count to zero at that edge, whatever the data. This wins over a step due at the same edge.
- R6: The event output is high for exactly the one cycle that follows a step taken while the count equaled the compare value. It is low otherwise.
- R7: When control bit 1 (return-to-zero) is 1, the step taken from the compare value loads zero instead of compare plus one. With a compare value of 0, the count therefore stays at 0 and an event follows every step.
- R8: The divider field d (0 to 3) gives one count-enable strobe every d+1 clocks. The divider phase restarts while run is 0, so the first step comes d+1 edges after the edge that sets run.
- R9: With return-to-zero at 0, the count passes the compare value and keeps rising, wrapping modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed location |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr, combinational |
| evt_pulse | output | 1 | One-cycle compare event |

## Verification
A wrong count shows on the count location in the same cycle as the bad step. A bad event pulse, or a missing one, shows one cycle after the step from the compare value. A divider phase that is off by one moves every later step by a whole clock, so a sample taken one edge before the expected step catches it. Frozen or cleared counts are read back over several idle cycles, so a step that sneaks through is seen within one clock of when it happens.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic [2:0] {
        SEL_CMP   = 3'd0,
        SEL_CNT   = 3'd1,
        SEL_CTRL  = 3'd2,
        SEL_CLEAR = 3'd3,
        SEL_DIV   = 3'd4,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    // control field: bit 1 return-to-zero, bit 0 run
    typedef struct packed {
        logic rtz;
        logic run;
    } ctrl_t;

    localparam int unsigned NUM_WORDS = 5;

    function automatic reg_sel_e sel_of(input logic [2:0] word);
        case (word)
            3'd0:    return SEL_CMP;
            3'd1:    return SEL_CNT;
            3'd2:    return SEL_CTRL;
            3'd3:    return SEL_CLEAR;
            3'd4:    return SEL_DIV;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  cmp_q,
    output ctrl_t             ctrl_q,
    output logic [DIV_W-1:0]  div_q,
    output logic              clr_stb,
    output logic [CNT_W-1:0]  rdata
);
    localparam int unsigned CTRL_W = $bits(ctrl_t);

    logic [ADDR_W-1:0] word;
    reg_sel_e          sel;

    always_comb begin
        word = addr >> 2;
        if (addr[1:0] == 2'b00 && word < ADDR_W'(NUM_WORDS))
            sel = sel_of(word[2:0]);
        else
            sel = SEL_NONE;
    end

    assign clr_stb = we && (sel == SEL_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '1;
            ctrl_q <= '0;
            div_q  <= '0;
        end else if (we) begin
            case (sel)
                SEL_CMP:  cmp_q  <= wdata;
                SEL_CTRL: ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
                SEL_DIV:  div_q  <= wdata[DIV_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_CMP:  rdata = cmp_q;
            SEL_CNT:  rdata = count;
            SEL_CTRL: rdata = CNT_W'(ctrl_q);
            SEL_DIV:  rdata = CNT_W'(div_q);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/evt_timer_presc.sv
module evt_timer_presc #(
    parameter int unsigned DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase;

    // >= so that lowering the divider mid-run cannot strand the phase
    assign tick = run && (phase >= div);

    always_ff @(posedge clk) begin
        if (rst || !run)
            phase <= '0;
        else if (tick)
            phase <= '0;
        else
            phase <= phase + DIV_W'(1);
    end

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             rtz,
    input  logic             tick,
    input  logic             clr_stb,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] count,
    output logic             evt
);
    logic hit;
    logic step;

    assign hit  = (count == cmp);
    assign step = run && tick && !clr_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            evt   <= 1'b0;
        end else begin
            evt <= step && hit;
            if (clr_stb)
                count <= '0;
            else if (step)
                count <= (rtz && hit) ? '0 : count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              evt_pulse
);
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] count;
    ctrl_t            ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic             clr_stb;
    logic             tick;

    evt_timer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .count   (count),
        .cmp_q   (cmp_q),
        .ctrl_q  (ctrl_q),
        .div_q   (div_q),
        .clr_stb (clr_stb),
        .rdata   (bus_rdata)
    );

    evt_timer_presc #(.DIV_W(DIV_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.run),
        .div  (div_q),
        .tick (tick)
    );

    evt_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .rtz     (ctrl_q.rtz),
        .tick    (tick),
        .clr_stb (clr_stb),
        .cmp     (cmp_q),
        .count   (count),
        .evt     (evt_pulse)
    );

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             rtz,
    input logic             tick,
    input logic             clr_stb,
    input logic [CNT_W-1:0] cmp,
    input logic [CNT_W-1:0] count,
    input logic             evt
);
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_stb |=> (count == '0)); // R5

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr_stb) |=> $stable(count)); // R4

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !clr_stb && !(rtz && count == cmp))
        |=> (count == $past(count) + CNT_W'(1))); // R3

    AST_RTZ_LOAD: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !clr_stb && rtz && count == cmp) |=> (count == '0)); // R7

    AST_EVT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !clr_stb && count == cmp) |=> evt); // R6

    AST_EVT_ONLY_HIT: assert property (@(posedge clk) disable iff (rst)
        !(run && tick && !clr_stb && count == cmp) |=> !evt); // R6

    AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run |-> !tick); // R8

endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q.run),
    .rtz     (ctrl_q.rtz),
    .tick    (tick),
    .clr_stb (clr_stb),
    .cmp     (cmp_q),
    .count   (count),
    .evt     (evt_pulse)
);

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 5;
    localparam int CNT_W  = 32;

    localparam logic [ADDR_W-1:0] A_CMP   = 5'h00;
    localparam logic [ADDR_W-1:0] A_CNT   = 5'h04;
    localparam logic [ADDR_W-1:0] A_CTRL  = 5'h08;
    localparam logic [ADDR_W-1:0] A_CLEAR = 5'h0C;
    localparam logic [ADDR_W-1:0] A_DIV   = 5'h10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [CNT_W-1:0]  bus_wdata = '0;
    logic [CNT_W-1:0]  bus_rdata;
    logic              evt_pulse;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_timer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIV_W(2)) u_evt_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_pulse (evt_pulse)
    );

    task automatic check(input string tag, input logic [CNT_W-1:0] got,
                         input logic [CNT_W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [CNT_W-1:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_cnt(input string tag, input logic [CNT_W-1:0] exp);
        logic [CNT_W-1:0] v;
        rd(A_CNT, v);
        check(tag, v, exp);
    endtask

    task automatic chk_evt(input string tag, input logic exp);
        check(tag, {31'b0, evt_pulse}, {31'b0, exp});
    endtask

    task automatic t_reset;
        logic [CNT_W-1:0] v;
        rd(A_CTRL, v);  check("R1 ctrl", v, 0);
        rd(A_CNT, v);   check("R1 count", v, 0);
        rd(A_CMP, v);   check("R1 compare", v, '1);
        rd(A_DIV, v);   check("R1 divider", v, 0);
        chk_evt("R1 event", 1'b0);
    endtask

    task automatic t_readback;
        logic [CNT_W-1:0] v;
        wr(A_CMP, 32'hA5A5_0F0F);
        rd(A_CMP, v);   check("R2 compare", v, 32'hA5A5_0F0F);
        wr(A_DIV, 32'hFF);
        rd(A_DIV, v);   check("R2 divider", v, 3);
        wr(A_DIV, 0);
        wr(A_CTRL, 32'h7);
        rd(A_CTRL, v);  check("R2 ctrl", v, 3);
        wr(A_CTRL, 0);
        rd(A_CLEAR, v); check("R2 clear reads 0", v, 0);
        rd(5'h14, v);   check("R2 unmapped", v, 0);
        rd(5'h02, v);   check("R2 unaligned", v, 0);
    endtask

    task automatic t_free_run;
        wr(A_CTRL, 0); wr(A_CLEAR, 0); wr(A_CMP, 5); wr(A_CTRL, 1);
        step(5);
        chk_cnt("R3 count 5", 5);
        chk_evt("R6 no event yet", 1'b0);
        step(1);
        chk_cnt("R9 passes compare", 6);
        chk_evt("R6 event after hit", 1'b1);
        wr(A_CTRL, 0);
        chk_cnt("R4 last step", 7);
        chk_evt("R6 single pulse", 1'b0);
        step(3);
        chk_cnt("R4 frozen", 7);
        wr(A_CNT, 32'h1234);
        chk_cnt("R3 count write ignored", 7);
    endtask

    task automatic t_rtz;
        wr(A_CLEAR, 32'hDEAD);
        chk_cnt("R5 clear any data", 0);
        wr(A_CMP, 3); wr(A_CTRL, 3);
        step(3);
        chk_cnt("R7 at compare", 3);
        chk_evt("R7 no event", 1'b0);
        step(1);
        chk_cnt("R7 back to zero", 0);
        chk_evt("R6 periodic event 1", 1'b1);
        step(3);
        chk_evt("R6 quiet", 1'b0);
        step(1);
        chk_cnt("R7 zero again", 0);
        chk_evt("R6 periodic event 2", 1'b1);
        step(1);
        chk_cnt("R7 restart", 1);
        wr(A_CLEAR, 0);
        chk_cnt("R5 clear beats step", 0);
        step(1);
        chk_cnt("R5 resumes", 1);
    endtask

    task automatic t_cmp_zero;
        wr(A_CTRL, 0); wr(A_CLEAR, 0); wr(A_CMP, 0); wr(A_CTRL, 3);
        step(1);
        chk_cnt("R7 stays zero", 0);
        chk_evt("R7 event each step a", 1'b1);
        step(1);
        chk_cnt("R7 still zero", 0);
        chk_evt("R7 event each step b", 1'b1);
    endtask

    task automatic t_div4;
        wr(A_CTRL, 0); wr(A_DIV, 3); wr(A_CLEAR, 0); wr(A_CMP, 2); wr(A_CTRL, 1);
        step(3);
        chk_cnt("R8 div4 before first", 0);
        step(1);
        chk_cnt("R8 div4 first", 1);
        step(7);
        chk_cnt("R8 div4 hold", 2);
        chk_evt("R8 div4 no event", 1'b0);
        step(1);
        chk_cnt("R8 div4 third", 3);
        chk_evt("R6 div4 event", 1'b1);
        step(1);
        chk_evt("R6 div4 one cycle", 1'b0);
    endtask

    task automatic t_div2;
        wr(A_CTRL, 0); wr(A_DIV, 1); wr(A_CLEAR, 0); wr(A_CTRL, 1);
        step(1);
        chk_cnt("R8 div2 wait", 0);
        step(1);
        chk_cnt("R8 div2 first", 1);
        step(2);
        chk_cnt("R8 div2 second", 2);
        wr(A_CTRL, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_readback;
        t_free_run;
        t_rtz;
        t_cmp_zero;
        t_div4;
        t_div2;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule